// File: doc/BRIEF.md
# Product-Term Logic Cell

This block is one logic cell of a programmable fabric. Eighteen logic inputs feed a shared pool of twenty product terms. Each term can use any input in true form, complement form, or not at all. Each of the four outputs either takes the OR of a chosen subset of the pool and inverts it when its polarity bit is set, or takes a fast OR of its own four dedicated terms. Each output is then passed through directly or taken from a D flip-flop.

Three terms of the pool have a second use. Term 16 can clear the cell's registers asynchronously. Term 17 can replace the global clock as the register clock. Term 18 can drive the output-enable that goes towards the pin cells. All configuration arrives as static input vectors and is held constant while the cell runs. An active-low global reset clears every register whatever the product terms are doing.

Top module: `glb_pterm_cell`

## Requirements
- R1: Product term t is 1 only when at least one of its literal enables is set and every enabled literal is true. Bit t*18+i of `cfg_lit_true` enables input i in true form. Bit t*18+i of `cfg_lit_comp` enables input i in complement form. A term with no enabled literal is 0.
- R2: When `cfg_fast[j]`=0, the data value of output j is the OR of every term k with `cfg_sum_mask[j*20+k]`=1, XORed with `cfg_invert[j]`.
- R3: When `cfg_fast[j]`=1, the data value of output j is the OR of terms 4j to 4j+3. The sum mask and `cfg_invert[j]` have no effect on it.
- R4: When `cfg_reg[j]`=0, `dout[j]` follows the data value combinationally, without any clock edge.
- R5: When `cfg_reg[j]`=1 and `cfg_clk_pt_sel`=0, `dout[j]` takes the data value present at each rising edge of `clk` and holds it between edges.
- R6: While `rst_n` is low, every register reads 0. The clear is asynchronous and takes effect whatever the product terms or clocks are doing.
- R7: When `cfg_rst_pt_en`=1, term 16 being 1 clears every register asynchronously. When `cfg_rst_pt_en`=0, term 16 has no effect on the registers.
- R8: When `cfg_clk_pt_sel`=1, the registers capture on rising edges of term 17 and ignore `clk`.
- R9: `oe` equals term 18 when `cfg_oe_pt_en`=1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| din | input | 18 | Logic inputs |
| cfg_lit_true | input | 360 | True-form literal enables, 18 per term |
| cfg_lit_comp | input | 360 | Complement-form literal enables, 18 per term |
| cfg_sum_mask | input | 80 | Per-output selection of pool terms, 20 per output |
| cfg_invert | input | 4 | Per-output polarity of the wide path |
| cfg_fast | input | 4 | Per-output choice of the four-term fast path |
| cfg_reg | input | 4 | Per-output choice of the registered output |
| cfg_rst_pt_en | input | 1 | Lets term 16 clear the registers |
| cfg_clk_pt_sel | input | 1 | Clocks the registers from term 17 |
| cfg_oe_pt_en | input | 1 | Drives `oe` from term 18 |
| dout | output | 4 | Cell outputs |
| oe | output | 1 | Output-enable towards the pin cells |

## Verification
The assertions assume that configuration changes only while `rst_n` is low. The bench therefore changes every configuration vector inside a reset window. The capture check assumes that a term-16 reset pulse stays asserted across the clock edge that follows its start. The bench holds every such pulse for a full cycle. All input changes happen just after a falling edge, so nothing moves near the rising edge at which the registers and clocked properties sample.

// File: rtl/glb_pkg.sv
package glb_pkg;
  localparam int MAXW = 64;

  // One product term: some literal enabled, no enabled literal false.
  function automatic logic pt_eval(input logic [MAXW-1:0] x,
                                   input logic [MAXW-1:0] en_t,
                                   input logic [MAXW-1:0] en_c);
    logic hit;
    logic any;
    hit = 1'b1;
    any = 1'b0;
    for (int i = 0; i < MAXW; i++) begin
      if (en_t[i]) begin
        any = 1'b1;
        if (!x[i]) hit = 1'b0;
      end
      if (en_c[i]) begin
        any = 1'b1;
        if (x[i]) hit = 1'b0;
      end
    end
    return any & hit;
  endfunction

  // Masked OR over a term vector.
  function automatic logic or_masked(input logic [MAXW-1:0] pts,
                                     input logic [MAXW-1:0] mask);
    return |(pts & mask);
  endfunction

  // Output path choice: fast OR or wide sum with polarity.
  function automatic logic path_pick(input logic fast_sel, input logic fast_v,
                                     input logic sum_v, input logic inv);
    return fast_sel ? fast_v : (sum_v ^ inv);
  endfunction
endpackage

// File: rtl/glb_and_array.sv
module glb_and_array
  import glb_pkg::*;
#(
  parameter int N_IN = 18,
  parameter int N_PT = 20
) (
  input  logic [N_IN-1:0]      din,
  input  logic [N_PT*N_IN-1:0] lit_t,
  input  logic [N_PT*N_IN-1:0] lit_c,
  output logic [N_PT-1:0]      pt
);
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt[t] = pt_eval(MAXW'(din),
                           MAXW'(lit_t[t*N_IN +: N_IN]),
                           MAXW'(lit_c[t*N_IN +: N_IN]));
  end
endmodule

// File: rtl/glb_sum_xor.sv
module glb_sum_xor
  import glb_pkg::*;
#(
  parameter int N_PT   = 20,
  parameter int N_OUT  = 4,
  parameter int N_FAST = 4
) (
  input  logic [N_PT-1:0]       pt,
  input  logic [N_OUT*N_PT-1:0] sum_mask,
  input  logic [N_OUT-1:0]      invert,
  input  logic [N_OUT-1:0]      fast_sel,
  output logic [N_OUT-1:0]      d
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic sum_v;
    logic fast_v;
    assign sum_v  = or_masked(MAXW'(pt), MAXW'(sum_mask[j*N_PT +: N_PT]));
    assign fast_v = |pt[j*N_FAST +: N_FAST];
    assign d[j]   = path_pick(fast_sel[j], fast_v, sum_v, invert[j]);
  end
endmodule

// File: rtl/glb_reg_bank.sv
module glb_reg_bank #(
  parameter int N_OUT = 4
) (
  input  logic             clk_glb,
  input  logic             clk_pt,
  input  logic             clk_pt_sel,
  input  logic             rst_n,
  input  logic             rst_pt_hit,
  input  logic [N_OUT-1:0] d,
  output logic [N_OUT-1:0] q
);
  logic reg_clk;
  logic arst_n;

  assign reg_clk = clk_pt_sel ? clk_pt : clk_glb;
  assign arst_n  = rst_n & ~rst_pt_hit;

  always_ff @(posedge reg_clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= d;
  end
endmodule

// File: rtl/glb_pterm_cell.sv
module glb_pterm_cell #(
  parameter int N_IN   = 18,
  parameter int N_PT   = 20,
  parameter int N_OUT  = 4,
  parameter int N_FAST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       din,
  input  logic [N_PT*N_IN-1:0]  cfg_lit_true,
  input  logic [N_PT*N_IN-1:0]  cfg_lit_comp,
  input  logic [N_OUT*N_PT-1:0] cfg_sum_mask,
  input  logic [N_OUT-1:0]      cfg_invert,
  input  logic [N_OUT-1:0]      cfg_fast,
  input  logic [N_OUT-1:0]      cfg_reg,
  input  logic                  cfg_rst_pt_en,
  input  logic                  cfg_clk_pt_sel,
  input  logic                  cfg_oe_pt_en,
  output logic [N_OUT-1:0]      dout,
  output logic                  oe
);
  localparam int PT_RST = N_OUT * N_FAST;
  localparam int PT_CLK = PT_RST + 1;
  localparam int PT_OE  = PT_RST + 2;

  logic [N_PT-1:0]  pt_vec;
  logic [N_OUT-1:0] d_vec;
  logic [N_OUT-1:0] q_vec;
  logic             pt_rst_hit;
  logic             pt_clk;

  glb_and_array #(.N_IN(N_IN), .N_PT(N_PT)) and_i (
    .din   (din),
    .lit_t (cfg_lit_true),
    .lit_c (cfg_lit_comp),
    .pt    (pt_vec)
  );

  glb_sum_xor #(.N_PT(N_PT), .N_OUT(N_OUT), .N_FAST(N_FAST)) sum_i (
    .pt       (pt_vec),
    .sum_mask (cfg_sum_mask),
    .invert   (cfg_invert),
    .fast_sel (cfg_fast),
    .d        (d_vec)
  );

  assign pt_rst_hit = cfg_rst_pt_en & pt_vec[PT_RST];
  assign pt_clk     = pt_vec[PT_CLK];

  glb_reg_bank #(.N_OUT(N_OUT)) reg_i (
    .clk_glb    (clk),
    .clk_pt     (pt_clk),
    .clk_pt_sel (cfg_clk_pt_sel),
    .rst_n      (rst_n),
    .rst_pt_hit (pt_rst_hit),
    .d          (d_vec),
    .q          (q_vec)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_omux
    assign dout[j] = cfg_reg[j] ? q_vec[j] : d_vec[j];
  end

  assign oe = cfg_oe_pt_en ? pt_vec[PT_OE] : 1'b1;
endmodule

// File: rtl/glb_pterm_cell_chk.sv
module glb_pterm_cell_chk #(
  parameter int N_OUT  = 4,
  parameter int N_FAST = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_OUT-1:0]        cfg_fast,
  input logic [N_OUT-1:0]        cfg_reg,
  input logic                    cfg_clk_pt_sel,
  input logic                    cfg_oe_pt_en,
  input logic [N_OUT*N_FAST-1:0] fast_pts,
  input logic [N_OUT-1:0]        d_vec,
  input logic [N_OUT-1:0]        q_vec,
  input logic                    pt_rst_hit,
  input logic [N_OUT-1:0]        dout,
  input logic                    oe
);
  // R6: registers are empty whenever the global reset is low
  always @(posedge clk) begin
    if (!rst_n) begin
      p_glb_rst_clear_r6: assert (q_vec == '0);
    end
  end

  // R7: a firing reset term leaves the registers empty
  always @(posedge clk) begin
    if (rst_n && pt_rst_hit) begin
      p_pt_rst_clear_r7: assert (q_vec == '0);
    end
  end

  // R9: output-enable defaults high
  always @(posedge clk) begin
    if (rst_n && !cfg_oe_pt_en) begin
      p_oe_default_r9: assert (oe);
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_lane
    // R3: combinational fast lane equals the OR of its own four terms
    always @(posedge clk) begin
      if (rst_n && cfg_fast[j] && !cfg_reg[j]) begin
        p_fast_lane_r3: assert (dout[j] == |fast_pts[j*N_FAST +: N_FAST]);
      end
    end

    // R5: registered lane shows the data value of the previous global edge
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_reg[j] && !cfg_clk_pt_sel && !pt_rst_hit) |=>
      (pt_rst_hit || !cfg_reg[j] || cfg_clk_pt_sel || dout[j] == $past(d_vec[j])));
  end
endmodule

bind glb_pterm_cell glb_pterm_cell_chk #(.N_OUT(N_OUT), .N_FAST(N_FAST)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_fast       (cfg_fast),
  .cfg_reg        (cfg_reg),
  .cfg_clk_pt_sel (cfg_clk_pt_sel),
  .cfg_oe_pt_en   (cfg_oe_pt_en),
  .fast_pts       (pt_vec[N_OUT*N_FAST-1:0]),
  .d_vec          (d_vec),
  .q_vec          (q_vec),
  .pt_rst_hit     (pt_rst_hit),
  .dout           (dout),
  .oe             (oe)
);

// File: tb/glb_pterm_cell_tb.sv
module glb_pterm_cell_tb_top;
  localparam int NI = 18;
  localparam int NP = 20;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    din = '0;
  logic [NP*NI-1:0] lt = '0;
  logic [NP*NI-1:0] lc = '0;
  logic [NO*NP-1:0] msk = '0;
  logic [NO-1:0]    inv = '0;
  logic [NO-1:0]    fst = '0;
  logic [NO-1:0]    rgs = '0;
  logic rst_en = 1'b0;
  logic clk_sel = 1'b0;
  logic oe_en = 1'b0;
  logic [NO-1:0] dout;
  logic oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  glb_pterm_cell dut_i (
    .clk(clk), .rst_n(rst_n), .din(din),
    .cfg_lit_true(lt), .cfg_lit_comp(lc), .cfg_sum_mask(msk),
    .cfg_invert(inv), .cfg_fast(fst), .cfg_reg(rgs),
    .cfg_rst_pt_en(rst_en), .cfg_clk_pt_sel(clk_sel), .cfg_oe_pt_en(oe_en),
    .dout(dout), .oe(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference term: walk the literals one by one
  function automatic logic ref_pt(input int t, input logic [NI-1:0] x);
    int used = 0;
    int met = 0;
    for (int i = 0; i < NI; i++) begin
      if (lt[t*NI+i]) begin used++; if (x[i]) met++; end
      if (lc[t*NI+i]) begin used++; if (!x[i]) met++; end
    end
    return (used > 0) && (used == met);
  endfunction

  function automatic logic [NO-1:0] ref_data(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int j = 0; j < NO; j++) begin
      logic acc = 1'b0;
      if (fst[j]) begin
        for (int k = 4*j; k < 4*j+4; k++) acc = acc | ref_pt(k, x);
        r[j] = acc;
      end else begin
        for (int k = 0; k < NP; k++) if (msk[j*NP+k]) acc = acc | ref_pt(k, x);
        r[j] = acc ^ inv[j];
      end
    end
    return r;
  endfunction

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lt = '0; lc = '0; msk = '0; inv = '0; fst = '0; rgs = '0;
    rst_en = 1'b0; clk_sel = 1'b0; oe_en = 1'b0; din = '0;
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rand_cfg(input logic use_fast, input logic use_reg);
    for (int t = 0; t < NP; t++)
      for (int k = 0; k < 3; k++) begin
        int i = int'($urandom % NI);
        if ($urandom % 2) lt[t*NI+i] = 1'b1; else lc[t*NI+i] = 1'b1;
      end
    for (int b = 0; b < NO*NP; b++) msk[b] = ($urandom % 4 == 0);
    inv = NO'($urandom);
    fst = use_fast ? NO'($urandom) : '0;
    rgs = use_reg ? NO'($urandom) : '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [NO-1:0] exp_q;
    // reset state, R6
    enter_reset();
    rgs = '1; inv = '1;
    @(negedge clk); #1;
    chk("R6 reset state", 32'(dout), 32'h0);
    chk("R9 oe reset default", 32'(oe), 32'h1);

    // R1 directed: term 0 = din[0] & ~din[5]; term 19 empty
    enter_reset();
    lt[0*NI+0] = 1'b1; lc[0*NI+5] = 1'b1;
    msk[0*NP+0] = 1'b1; msk[1*NP+19] = 1'b1;
    leave_reset();
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      din = '0; din[0] = v[0]; din[5] = v[1];
      #1;
      chk("R1 literal term", 32'(dout[0]), 32'(v == 1));
      chk("R1 empty term is 0", 32'(dout[1]), 32'h0);
    end

    // R3 directed: fast lane ignores mask and polarity
    enter_reset();
    lt[19*NI+4] = 1'b1; msk[0*NP+19] = 1'b1; fst[0] = 1'b1; inv[0] = 1'b1;
    lt[2*NI+6] = 1'b1;
    leave_reset();
    @(negedge clk); din = '0; din[4] = 1'b1; #1;
    chk("R3 fast ignores mask/invert", 32'(dout[0]), 32'h0);
    @(negedge clk); din[6] = 1'b1; #1;
    chk("R3 fast lane term 2", 32'(dout[0]), 32'h1);

    // R2 R3 R4: random combinational sweeps
    for (int c = 0; c < 6; c++) begin
      enter_reset();
      rand_cfg(c >= 3, 1'b0);
      leave_reset();
      for (int v = 0; v < 150; v++) begin
        @(negedge clk);
        din = NI'($urandom);
        #1;
        chk(c >= 3 ? "R3 R4 sweep" : "R2 R4 sweep", 32'(dout), 32'(ref_data(din)));
      end
      chk("R9 oe default sweep", 32'(oe), 32'h1);
    end

    // R5 R4: random mixed registered/combinational sweeps
    for (int c = 0; c < 4; c++) begin
      enter_reset();
      rand_cfg(c[0], 1'b1);
      leave_reset();
      @(negedge clk); din = NI'($urandom);
      @(posedge clk); #1; exp_q = ref_data(din);
      for (int v = 0; v < 120; v++) begin
        @(negedge clk);
        din = NI'($urandom);
        #1;
        chk("R5 hold between edges", 32'(dout), 32'((rgs & exp_q) | (~rgs & ref_data(din))));
        @(posedge clk); #1;
        exp_q = ref_data(din);
        chk("R5 capture at edge", 32'(dout), 32'((rgs & exp_q) | (~rgs & ref_data(din))));
      end
    end

    // R6: global reset clears asynchronously and holds
    enter_reset();
    rgs = '1; inv = '1;
    leave_reset();
    @(posedge clk); #1;
    chk("R5 load ones", 32'(dout), 32'hF);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R6 async clear", 32'(dout), 32'h0);
    repeat (2) @(posedge clk);
    #1;
    chk("R6 held through edges", 32'(dout), 32'h0);

    // R7: term-16 reset ignored when disabled
    enter_reset();
    rgs = '1; inv = '1; lt[16*NI+0] = 1'b1;
    leave_reset();
    @(negedge clk); din[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R7 disabled reset term ignored", 32'(dout), 32'hF);
    // R7: enabled, clears without a clock edge
    enter_reset();
    rgs = '1; inv = '1; lt[16*NI+0] = 1'b1; rst_en = 1'b1;
    leave_reset();
    @(posedge clk); #1;
    chk("R7 preload", 32'(dout), 32'hF);
    @(negedge clk); din[0] = 1'b1; #1;
    chk("R7 async term reset", 32'(dout), 32'h0);
    @(posedge clk); #1;
    chk("R7 reset term holds", 32'(dout), 32'h0);
    @(negedge clk); din[0] = 1'b0;
    @(posedge clk); #1;
    chk("R7 release", 32'(dout), 32'hF);

    // R8: term-17 clock
    enter_reset();
    rgs = '1; clk_sel = 1'b1; lt[17*NI+1] = 1'b1; lt[0*NI+3] = 1'b1;
    for (int j = 0; j < NO; j++) msk[j*NP+0] = 1'b1;
    leave_reset();
    @(negedge clk); din[3] = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 global clock ignored", 32'(dout), 32'h0);
    @(negedge clk); din[1] = 1'b1; #1;
    chk("R8 term clock capture", 32'(dout), 32'hF);
    @(negedge clk); din[1] = 1'b0; din[3] = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 hold without term edge", 32'(dout), 32'hF);
    @(negedge clk); din[1] = 1'b1; #1;
    chk("R8 second term edge", 32'(dout), 32'h0);

    // R9: output enable from term 18 (complement of din[2])
    enter_reset();
    lc[18*NI+2] = 1'b1; oe_en = 1'b1;
    leave_reset();
    @(negedge clk); din[2] = 1'b0; #1;
    chk("R9 oe term true", 32'(oe), 32'h1);
    @(negedge clk); din[2] = 1'b1; #1;
    chk("R9 oe term false", 32'(oe), 32'h0);
    enter_reset();
    lc[18*NI+2] = 1'b1;
    leave_reset();
    @(negedge clk); din[2] = 1'b1; #1;
    chk("R9 oe default high", 32'(oe), 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule